// File: doc/BRIEF.md
# Banked Pipelined Bus Fabric

This block carries single read and write transactions from one granted master through a fixed four-slot pipeline into a matrix of user-logic banks. A request is taken into an entry slot, driven out as address, data and control in the next slot, decoded by the window selectors of every bank in the third slot, and returned to the master from the fourth slot. Each bank keeps its own copy of the decode-stage pipeline register, so the distance between banks never shortens the time user logic has to answer.

Every selector owns a window of four byte-wide cells and is given a base tag and an enable through a configuration port, which only takes effect while the fabric is empty. A write lands only in the addressed cell of the matching selector. Read data from every selector is ORed onto one return line, and a selector that is not hit drives zeros. A hit always costs one automatic wait cycle. The user logic behind the hit selector can stretch that wait. All wait sources are ORed into one stall, and that stall freezes the pipeline registers of all banks and of the front slots together.

Top module: `banked_bus_fabric`

## Requirements
- R1: While `rst_n` is low and after its release, no response is pending, `req_ready` is 1 and every selector is disabled, so any read returns zero as a miss.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1; `req_ready` is 0 in every cycle in which the fabric stalls.
- R3: A transaction that hits no enabled selector produces `rsp_valid` in the cycle after the third rising edge following the edge that took it, as a single-cycle pulse.
- R4: A read that hits no enabled selector returns `rsp_rdata` of zero.
- R5: A transaction that hits an enabled selector stalls exactly one automatic cycle, so `rsp_valid` follows the fourth rising edge after the taking edge.
- R6: A selector matches when it is enabled and address bits [15:2] equal its tag; address bits [1:0] pick one of its four cells.
- R7: A write changes only the addressed cell of each matching selector; every other cell keeps its value.
- R8: Read data is the bitwise OR of the addressed cells of all matching selectors; disabled or unmatched selectors contribute zero.
- R9: While the `usr_wait` bit of a hit selector is 1 (bit index = bank*8 + selector), the stall continues past the automatic cycle; the response follows the first edge at which that bit is 0. A `usr_wait` bit of a selector that is not hit has no effect.
- R10: During a stall every pipeline stage in the front slots and in all banks holds its transaction; a request queued behind a stalled one completes in order one cycle after it.
- R11: A configuration write loads the selector at index `cfg_idx` = bank*8 + selector with `cfg_tag` and `cfg_en`, and only when no transaction is in flight and `req_valid` is 0; otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Master presents a request |
| req_ready | output | 1 | Entry slot takes the request this edge |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 16 | Transaction address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data returned with the pulse (zero for writes and misses) |
| usr_wait | input | 32 | Per-selector wait extension from user logic |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 5 | Selector index, bank*8 + selector |
| cfg_tag | input | 14 | Window tag compared with address bits [15:2] |
| cfg_en | input | 1 | Selector enable |

## Verification
The bench sweeps all 32 selectors, writing and reading every cell, and counts edges to each response, so a design that forgets the automatic wait answers one cycle early, and one that waits on misses answers late. Probes just beside each window catch a decoder comparing too few tag bits, which would return data for a neighbour address. An overlapping pair of selectors shows whether the return line is truly ORed or one source wins, and a request queued behind a hit shows whether a stall freezes every stage or lets one slip and drop or duplicate a transaction. Held user waits, waits on an unselected selector, and configuration attempted while a request is in flight each expose a stall or configuration path wired to the wrong qualifier.

// File: rtl/fab_pkg.sv
package fab_pkg;
  localparam int unsigned FAB_BANKS   = 4;
  localparam int unsigned FAB_SELS    = 8;
  localparam int unsigned FAB_ADDR_W  = 16;
  localparam int unsigned FAB_DATA_W  = 8;
  localparam int unsigned FAB_CELL_AW = 2;

  typedef struct packed {
    logic vld;
    logic wr;
  } slot_ctl_t;
endpackage

// File: rtl/fab_selector.sv
module fab_selector #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CELL_AW = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_load,
  input  logic [ADDR_W-CELL_AW-1:0] cfg_tag,
  input  logic                      cfg_en,
  input  logic                      valid,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic                      wr_go,
  output logic                      hit,
  output logic [DATA_W-1:0]         rdata
);
  localparam int unsigned NCELL = 1 << CELL_AW;
  localparam int unsigned TAG_W = ADDR_W - CELL_AW;

  logic              en_q, en_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] cell_q [NCELL];
  logic [DATA_W-1:0] cell_d [NCELL];
  logic [CELL_AW-1:0] off;

  assign off   = addr[CELL_AW-1:0];
  assign hit   = valid && en_q && (addr[ADDR_W-1:CELL_AW] == tag_q);
  assign rdata = hit ? cell_q[off] : '0;

  always_comb begin
    en_d  = en_q;
    tag_d = tag_q;
    if (cfg_load) begin
      en_d  = cfg_en;
      tag_d = cfg_tag;
    end
  end

  always_comb begin
    for (int c = 0; c < NCELL; c++) cell_d[c] = cell_q[c];
    if (wr_go && hit) cell_d[off] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      tag_q <= '0;
    end else if (cfg_load) begin
      en_q  <= en_d;
      tag_q <= tag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCELL; c++) cell_q[c] <= '0;
    end else if (wr_go && hit) begin
      for (int c = 0; c < NCELL; c++) cell_q[c] <= cell_d[c];
    end
  end

  for (genvar c = 0; c < NCELL; c++) begin : g_cell_chk
    assert_cell_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_go && hit && (off == CELL_AW'(c))) |=> $stable(cell_q[c]));
  end
endmodule

// File: rtl/fab_front_pipe.sv
module fab_front_pipe import fab_pkg::*; #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NSTG   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              in_vld,
  input  logic              in_wr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output slot_ctl_t         out_ctl,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic              busy
);
  slot_ctl_t         ctl_q  [NSTG];
  slot_ctl_t         ctl_d  [NSTG];
  logic [ADDR_W-1:0] addr_q [NSTG];
  logic [ADDR_W-1:0] addr_d [NSTG];
  logic [DATA_W-1:0] data_q [NSTG];
  logic [DATA_W-1:0] data_d [NSTG];

  always_comb begin
    ctl_d[0]  = '{vld: in_vld, wr: in_wr};
    addr_d[0] = in_addr;
    data_d[0] = in_data;
    for (int s = 1; s < NSTG; s++) begin
      ctl_d[s]  = ctl_q[s-1];
      addr_d[s] = addr_q[s-1];
      data_d[s] = data_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSTG; s++) ctl_q[s] <= '0;
    end else if (!hold) begin
      for (int s = 0; s < NSTG; s++) ctl_q[s] <= ctl_d[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!hold) begin
      for (int s = 0; s < NSTG; s++) begin
        addr_q[s] <= addr_d[s];
        data_q[s] <= data_d[s];
      end
    end
  end

  always_comb begin
    busy = 1'b0;
    for (int s = 0; s < NSTG; s++) busy = busy | ctl_q[s].vld;
  end

  assign out_ctl  = ctl_q[NSTG-1];
  assign out_addr = addr_q[NSTG-1];
  assign out_data = data_q[NSTG-1];

  assert_front_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold && out_ctl.vld |=> out_ctl.vld && $stable(out_addr) && $stable(out_data));
endmodule

// File: rtl/fab_bank.sv
module fab_bank #(
  parameter int unsigned SELS    = 8,
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CELL_AW = 2,
  localparam int unsigned SEL_IW = (SELS > 1) ? $clog2(SELS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall,
  input  logic                      in_vld,
  input  logic                      in_wr,
  input  logic [ADDR_W-1:0]         in_addr,
  input  logic [DATA_W-1:0]         in_data,
  input  logic                      cfg_we,
  input  logic [SEL_IW-1:0]         cfg_sel,
  input  logic [ADDR_W-CELL_AW-1:0] cfg_tag,
  input  logic                      cfg_en,
  input  logic [SELS-1:0]           usr_wait,
  output logic [DATA_W-1:0]         rdata,
  output logic                      hit_any,
  output logic                      wait_req,
  output logic                      stage_vld
);
  logic              pv_q, pwr_q, pwaited_q;
  logic              pv_d, pwr_d, pwaited_d;
  logic [ADDR_W-1:0] paddr_q, paddr_d;
  logic [DATA_W-1:0] pdata_q, pdata_d;
  logic [SELS-1:0]   hit_v;
  logic [DATA_W-1:0] rd_v [SELS];
  logic              wr_go;

  always_comb begin
    pv_d      = pv_q;
    pwr_d     = pwr_q;
    paddr_d   = paddr_q;
    pdata_d   = pdata_q;
    pwaited_d = pv_q;
    if (!stall) begin
      pv_d      = in_vld;
      pwr_d     = in_wr;
      paddr_d   = in_addr;
      pdata_d   = in_data;
      pwaited_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q      <= 1'b0;
      pwr_q     <= 1'b0;
      pwaited_q <= 1'b0;
    end else begin
      pv_q      <= pv_d;
      pwr_q     <= pwr_d;
      pwaited_q <= pwaited_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!stall) begin
      paddr_q <= paddr_d;
      pdata_q <= pdata_d;
    end
  end

  assign wr_go = pwr_q && !stall;

  for (genvar g = 0; g < SELS; g++) begin : g_sel
    fab_selector #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CELL_AW(CELL_AW)
    ) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg_load(cfg_we && (cfg_sel == SEL_IW'(g))),
      .cfg_tag (cfg_tag),
      .cfg_en  (cfg_en),
      .valid   (pv_q),
      .addr    (paddr_q),
      .wdata   (pdata_q),
      .wr_go   (wr_go),
      .hit     (hit_v[g]),
      .rdata   (rd_v[g])
    );
  end

  always_comb begin
    rdata = '0;
    for (int g = 0; g < SELS; g++) rdata = rdata | rd_v[g];
  end

  assign hit_any   = |hit_v;
  assign wait_req  = (hit_any && !pwaited_q) || (|(hit_v & usr_wait));
  assign stage_vld = pv_q;

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stall && pv_q |=> pv_q && $stable(paddr_q) && $stable(pwr_q));

  assert_unhit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_any |-> rdata == '0);
endmodule

// File: rtl/banked_bus_fabric.sv
module banked_bus_fabric import fab_pkg::*; #(
  parameter int unsigned NUM_BANKS     = FAB_BANKS,
  parameter int unsigned SELS_PER_BANK = FAB_SELS,
  parameter int unsigned ADDR_W        = FAB_ADDR_W,
  parameter int unsigned DATA_W        = FAB_DATA_W,
  parameter int unsigned CELL_AW       = FAB_CELL_AW
) (
  input  logic                                       clk,
  input  logic                                       rst_n,
  input  logic                                       req_valid,
  output logic                                       req_ready,
  input  logic                                       req_write,
  input  logic [ADDR_W-1:0]                          req_addr,
  input  logic [DATA_W-1:0]                          req_wdata,
  output logic                                       rsp_valid,
  output logic [DATA_W-1:0]                          rsp_rdata,
  input  logic [NUM_BANKS*SELS_PER_BANK-1:0]         usr_wait,
  input  logic                                       cfg_we,
  input  logic [$clog2(NUM_BANKS*SELS_PER_BANK)-1:0] cfg_idx,
  input  logic [ADDR_W-CELL_AW-1:0]                  cfg_tag,
  input  logic                                       cfg_en
);
  localparam int unsigned NSEL   = NUM_BANKS * SELS_PER_BANK;
  localparam int unsigned IDX_W  = $clog2(NSEL);
  localparam int unsigned SEL_IW = (SELS_PER_BANK > 1) ? $clog2(SELS_PER_BANK) : 1;
  localparam int unsigned BNK_IW = IDX_W - SEL_IW;

  slot_ctl_t         f_ctl;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic              f_busy;
  logic              stall, idle, cfg_ok;

  logic [NUM_BANKS-1:0] b_hit, b_wait, b_vld;
  logic [DATA_W-1:0]    b_rd [NUM_BANKS];
  logic [DATA_W-1:0]    or_rd;
  logic                 any_hit;

  slot_ctl_t         st2_q, st2_d;
  logic              st3_vld_q, st3_vld_d;
  logic              st3_hit_q, st3_hit_d;
  logic [DATA_W-1:0] st3_rd_q, st3_rd_d;

  assign stall     = |b_wait;
  assign req_ready = !stall;
  assign idle      = !f_busy && !st2_q.vld && !st3_vld_q && !req_valid;
  assign cfg_ok    = cfg_we && idle;

  fab_front_pipe #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .NSTG  (2)
  ) u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (stall),
    .in_vld  (req_valid),
    .in_wr   (req_write),
    .in_addr (req_addr),
    .in_data (req_wdata),
    .out_ctl (f_ctl),
    .out_addr(f_addr),
    .out_data(f_data),
    .busy    (f_busy)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    fab_bank #(
      .SELS   (SELS_PER_BANK),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CELL_AW(CELL_AW)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .stall    (stall),
      .in_vld   (f_ctl.vld),
      .in_wr    (f_ctl.wr),
      .in_addr  (f_addr),
      .in_data  (f_data),
      .cfg_we   (cfg_ok && (cfg_idx[IDX_W-1:SEL_IW] == BNK_IW'(b))),
      .cfg_sel  (cfg_idx[SEL_IW-1:0]),
      .cfg_tag  (cfg_tag),
      .cfg_en   (cfg_en),
      .usr_wait (usr_wait[b*SELS_PER_BANK +: SELS_PER_BANK]),
      .rdata    (b_rd[b]),
      .hit_any  (b_hit[b]),
      .wait_req (b_wait[b]),
      .stage_vld(b_vld[b])
    );
  end

  always_comb begin
    or_rd = '0;
    for (int b = 0; b < NUM_BANKS; b++) or_rd = or_rd | b_rd[b];
  end
  assign any_hit = |b_hit;

  always_comb begin
    st2_d     = st2_q;
    st3_vld_d = st3_vld_q;
    st3_hit_d = st3_hit_q;
    st3_rd_d  = st3_rd_q;
    if (!stall) begin
      st2_d     = f_ctl;
      st3_vld_d = st2_q.vld;
      st3_hit_d = any_hit;
      st3_rd_d  = st2_q.wr ? '0 : or_rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st2_q     <= '0;
      st3_vld_q <= 1'b0;
      st3_hit_q <= 1'b0;
    end else begin
      st2_q     <= st2_d;
      st3_vld_q <= st3_vld_d;
      st3_hit_q <= st3_hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!stall) st3_rd_q <= st3_rd_d;
  end

  assign rsp_valid = st3_vld_q && !stall;
  assign rsp_rdata = st3_rd_q;

  assert_auto_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    st2_q.vld && any_hit && $past(!stall) |-> stall);

  assert_miss_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    st3_vld_q && !st3_hit_q |-> st3_rd_q == '0);

  assert_banks_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
    b_vld == {NUM_BANKS{st2_q.vld}});
endmodule

// File: tb/tb_banked_bus_fabric.sv
module tb_banked_bus_fabric;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic        req_ready;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [31:0] usr_wait;
  logic        cfg_we, cfg_en;
  logic [4:0]  cfg_idx;
  logic [13:0] cfg_tag;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  banked_bus_fabric dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .usr_wait(usr_wait),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_tag(cfg_tag), .cfg_en(cfg_en)
  );

  function automatic logic [15:0] base_of(int i);
    return 16'h0100 + 16'(i * 16);
  endfunction

  function automatic logic [7:0] dv(int i, int c);
    return 8'((i * 37 + c * 11 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic cfg(input int idx, input logic [15:0] base, input bit en);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 5'(idx); cfg_tag = base[15:2]; cfg_en = en;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic txn(input bit wr, input logic [15:0] addr, input logic [7:0] wd,
                     output logic [7:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 40) begin
      @(posedge clk); @(negedge clk); lat++;
    end
    rd = rsp_rdata;
    @(posedge clk); @(negedge clk);
    chk(!rsp_valid, "R3 single pulse", int'(rsp_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rd;
    int lat;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    usr_wait = '0; cfg_we = 1'b0; cfg_idx = '0; cfg_tag = '0; cfg_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid, "R1 no response in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", int'(req_ready), 1);

    // R1/R3/R4: all selectors disabled, everything misses
    txn(1'b0, base_of(0), 8'h00, rd, lat);
    chk(rd == 8'h00, "R1 disabled read zero", rd, 0);
    chk(lat == 3, "R3 miss latency", lat, 3);
    txn(1'b1, base_of(7), 8'h5A, rd, lat);
    chk(lat == 3, "R3 miss write latency", lat, 3);

    // R6/R11: configure every selector, index = bank*8 + selector
    for (int i = 0; i < 32; i++) cfg(i, base_of(i), 1'b1);

    // R5/R7: write every cell of every selector
    for (int i = 0; i < 32; i++)
      for (int c = 0; c < 4; c++) begin
        txn(1'b1, base_of(i) + 16'(c), dv(i, c), rd, lat);
        chk(lat == 4, "R5 hit write latency", lat, 4);
      end

    // R6/R7/R5: read back everything after all writes
    for (int i = 0; i < 32; i++)
      for (int c = 0; c < 4; c++) begin
        txn(1'b0, base_of(i) + 16'(c), 8'h00, rd, lat);
        chk(rd == dv(i, c), "R7 cell readback", rd, dv(i, c));
        chk(lat == 4, "R5 hit read latency", lat, 4);
      end

    // R6/R4: addresses beside each window miss
    for (int i = 0; i < 32; i++) begin
      txn(1'b0, base_of(i) + 16'd4, 8'h00, rd, lat);
      chk(rd == 8'h00, "R4 neighbour miss zero", rd, 0);
      chk(lat == 3, "R6 neighbour miss latency", lat, 3);
      txn(1'b0, base_of(i) ^ 16'h8000, 8'h00, rd, lat);
      chk(rd == 8'h00, "R6 high tag bit miss", rd, 0);
    end

    // R9: user wait on a selector that is not hit has no effect
    usr_wait = 32'h0000_0008;
    txn(1'b0, base_of(9) + 16'd1, 8'h00, rd, lat);
    chk(lat == 4, "R9 unhit wait ignored", lat, 4);
    chk(rd == dv(9, 1), "R9 unhit wait data", rd, dv(9, 1));

    // R9: held user wait on the hit selector stretches the stall
    usr_wait = 32'h0000_0200;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = base_of(9) + 16'd2;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 10; k++) begin
        @(posedge clk); @(negedge clk);
        if (rsp_valid) seen++;
      end
      chk(seen == 0, "R9 no response while user wait held", seen, 0);
      chk(!req_ready, "R2 ready low while stalled", int'(req_ready), 0);
    end
    usr_wait = '0;
    @(posedge clk); @(negedge clk);
    chk(rsp_valid, "R9 response after wait release", int'(rsp_valid), 1);
    chk(rsp_rdata == dv(9, 2), "R9 data after wait", rsp_rdata, dv(9, 2));
    @(posedge clk); @(negedge clk);

    // R10/R2: miss read queued behind a hit read
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = base_of(20) + 16'd3;
    @(posedge clk); @(negedge clk);
    req_addr = base_of(20) + 16'd8;
    begin
      int ta = -1, tb = -1;
      logic [7:0] da = 8'h00, db = 8'hFF;
      for (int c = 1; c <= 8; c++) begin
        @(posedge clk); @(negedge clk);
        if (c == 1) req_valid = 1'b0;
        if (c == 2) chk(!req_ready, "R2 ready low in auto wait", int'(req_ready), 0);
        if (rsp_valid && ta < 0) begin ta = c; da = rsp_rdata; end
        else if (rsp_valid && tb < 0) begin tb = c; db = rsp_rdata; end
      end
      chk(ta == 4, "R10 first response slot", ta, 4);
      chk(da == dv(20, 3), "R10 first response data", da, dv(20, 3));
      chk(tb == 5, "R10 queued response slot", tb, 5);
      chk(db == 8'h00, "R10 queued miss data", db, 0);
    end

    // R11: configuration attempt while a request is in flight is ignored
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = base_of(0);
    cfg_we = 1'b1; cfg_idx = 5'd0; cfg_tag = 14'h0; cfg_en = 1'b0;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0; cfg_we = 1'b0;
    repeat (6) @(posedge clk);
    txn(1'b0, base_of(0), 8'h00, rd, lat);
    chk(rd == dv(0, 0), "R11 busy config ignored data", rd, dv(0, 0));
    chk(lat == 4, "R11 busy config ignored hit", lat, 4);

    // R8: overlapping selectors OR their cells
    cfg(6, base_of(5), 1'b1);
    for (int c = 0; c < 4; c++) begin
      txn(1'b0, base_of(5) + 16'(c), 8'h00, rd, lat);
      chk(rd == (dv(5, c) | dv(6, c)), "R8 overlap OR", rd, dv(5, c) | dv(6, c));
    end
    txn(1'b0, base_of(6), 8'h00, rd, lat);
    chk(rd == 8'h00 && lat == 3, "R8 moved window misses", rd, 0);
    cfg(6, base_of(5), 1'b0);
    txn(1'b0, base_of(5) + 16'd1, 8'h00, rd, lat);
    chk(rd == dv(5, 1), "R8 disabled selector contributes zero", rd, dv(5, 1));

    // R11: idle disable takes effect
    cfg(31, base_of(31), 1'b0);
    txn(1'b0, base_of(31) + 16'd2, 8'h00, rd, lat);
    chk(rd == 8'h00 && lat == 3, "R11 idle disable applied", lat, 3);

    summary();
    $finish;
  end
endmodule